// File: doc/BRIEF.md
# Integer Execute Unit with Operand Shifter and Condition Flags

This block is the arithmetic and logic stage of a small 32-bit microcontroller pipeline. Each cycle it takes a first operand, a second operand and a decoded operation code, and it drives a 32-bit result combinationally. The second operand is either an immediate or a register value that first passes through a shifter. The shifter applies a rotate, a logical shift, an arithmetic shift, or a one-bit rotate through carry, and the shift amount is an immediate. Decode, register file and memory sit outside the block, and all controls arrive already decoded.

The block holds four condition flags: negative (N), zero (Z), carry (C) and overflow (V). They are stored in a status register that updates on the rising clock edge only when flag update is requested. The stored carry feeds back into two places: the add-with-carry and subtract-with-carry operations, and the rotate-through-carry shift. Flag-setting logical operations take their carry from the shifter.

Top module: `alu_exec_unit`

## Requirements
- R1: Arithmetic operations by `opcode`: 2 ADD = a+b, 3 ADC = a+b+C, 4 SUB = a-b, 5 SBC = a+~b+C, 6 RSB = b-a. In all of these, b is the selected second operand.
- R2: Logical operations by `opcode`: 0 AND = a&b, 1 EOR = a^b, 7 ORR = a|b, 8 ORN = a|~b, 9 BIC = a&~b.
- R3: When `use_imm`=0, the second operand is `op_b` shifted according to `shift_kind`: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX. The amount comes from `shift_amt`. An amount of 0 passes `op_b` unchanged for kinds 0 to 3. When `use_imm`=1, `imm` is used unshifted.
- R4: RRX shifts `op_b` right by one and puts the stored C flag into bit 31. Its carry-out is `op_b` bit 0. `shift_amt` is ignored for RRX.
- R5: `opcode` 10 (wide add) returns a + zero-extended `imm[11:0]`, whatever `use_imm` is. It never changes any flag, even when `set_flags`=1.
- R6: The flags reset to N=Z=C=V=0. They are written on a rising edge only when `set_flags`=1. Otherwise all four keep their value.
- R7: When flags are written, N = result bit 31 and Z = 1 exactly when the result is zero.
- R8: For add operations, C is the unsigned carry out of bit 31. For subtract operations, C=1 means no borrow (minuend unsigned >= subtrahend).
- R9: For add, V=1 when both addends have the same sign and the result sign differs from it. For subtract, V=1 when the operand signs differ and the result sign differs from the minuend's sign.
- R10: For a flag-setting logical operation, V is left unchanged. C takes the shifter carry-out when the register operand is shifted by a non-zero amount or by RRX. Otherwise (amount 0, or immediate operand) C is left unchanged.
- R11: The shifter carry-out is the last bit shifted out (ROR: result bit 31). ASR fills the vacated upper bits with the original bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, flags update on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| opcode | input | 4 | Decoded operation code (R1, R2, R5) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Register second operand, goes through the shifter |
| imm | input | 32 | Immediate second operand |
| use_imm | input | 1 | 1 selects `imm`, 0 selects shifted `op_b` |
| shift_kind | input | 3 | Shift type code (R3) |
| shift_amt | input | 5 | Immediate shift amount |
| set_flags | input | 1 | Request to write the flags on this edge |
| result | output | 32 | Operation result, combinational |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The assertions assume that `opcode` holds one of the eleven defined codes and that `shift_kind` holds one of the five defined codes. Undefined codes give no meaningful result or carry. The bench only ever drives defined codes. Each table case first sets the flags to N=0, Z=0, C=1, V=0 with a subtract of 1 minus 0, so every case starts from the same state and no case depends on the one before it. The RRX property also assumes the first operand is zero, so that the result exposes the inserted carry bit. The bench drives that pattern on purpose.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_EOR  = 4'd1,
        OP_ADD  = 4'd2,
        OP_ADC  = 4'd3,
        OP_SUB  = 4'd4,
        OP_SBC  = 4'd5,
        OP_RSB  = 4'd6,
        OP_ORR  = 4'd7,
        OP_ORN  = 4'd8,
        OP_BIC  = 4'd9,
        OP_ADDW = 4'd10
    } alu_op_e;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  shift_e        kind,
    input  logic [SW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  out,
    output logic          cout,
    output logic          cvalid
);
    localparam int EW = W + 1;

    logic [EW-1:0] left_ext;
    logic [EW-1:0] right_ext;
    logic [EW-1:0] arith_ext;
    logic [W-1:0]  rot;
    logic [SW:0]   inv_amt;

    always_comb begin
        inv_amt   = (SW+1)'(W) - {1'b0, amt};
        left_ext  = {1'b0, val} << amt;
        right_ext = {val, 1'b0} >> amt;
        arith_ext = EW'($signed({val, 1'b0}) >>> amt);
        rot       = (val >> amt) | (val << inv_amt);
    end

    always_comb begin
        out    = val;
        cout   = cin;
        cvalid = (amt != '0);
        unique case (kind)
            SH_LSL: begin
                out  = left_ext[W-1:0];
                cout = left_ext[W];
            end
            SH_LSR: begin
                out  = right_ext[EW-1:1];
                cout = right_ext[0];
            end
            SH_ASR: begin
                out  = arith_ext[EW-1:1];
                cout = arith_ext[0];
            end
            SH_ROR: begin
                out  = rot;
                cout = rot[W-1];
            end
            SH_RRX: begin
                out    = {cin, val[W-1:1]};
                cout   = val[0];
                cvalid = 1'b1;
            end
            default: begin
                out    = val;
                cout   = cin;
                cvalid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_arith,
    output logic         v_arith,
    output logic         is_logic
);
    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_ci;
    logic [W:0]   sum;

    always_comb begin
        add_x  = a;
        add_y  = b;
        add_ci = 1'b0;
        unique case (op)
            OP_ADC: add_ci = cin;
            OP_SUB: begin add_y = ~b; add_ci = 1'b1; end
            OP_SBC: begin add_y = ~b; add_ci = cin;  end
            OP_RSB: begin add_x = b; add_y = ~a; add_ci = 1'b1; end
            default: ;
        endcase
        sum     = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_ci};
        c_arith = sum[W];
        v_arith = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);
    end

    always_comb begin
        is_logic = 1'b1;
        unique case (op)
            OP_AND: res = a & b;
            OP_EOR: res = a ^ b;
            OP_ORR: res = a | b;
            OP_ORN: res = a | ~b;
            OP_BIC: res = a & ~b;
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_ADDW: begin
                res      = sum[W-1:0];
                is_logic = 1'b0;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  flags_t nxt,
    output flags_t cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (we) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
    import alu_pkg::*;
#(
    parameter int W          = 32,
    parameter int WIDE_IMM_W = 12,
    parameter int SW         = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    opcode,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [W-1:0]  imm,
    input  logic          use_imm,
    input  logic [2:0]    shift_kind,
    input  logic [SW-1:0] shift_amt,
    input  logic          set_flags,
    output logic [W-1:0]  result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v
);
    localparam int PAD_W = W - WIDE_IMM_W;

    alu_op_e      op;
    flags_t       flags_q;
    flags_t       flags_d;
    logic [W-1:0] sh_out;
    logic         sh_cout;
    logic         sh_cvalid;
    logic [W-1:0] operand2;
    logic [W-1:0] res;
    logic         c_arith;
    logic         v_arith;
    logic         is_logic;
    logic         flag_we;

    assign op = alu_op_e'(opcode);

    alu_shifter #(.W(W), .SW(SW)) u_shift (
        .val    (op_b),
        .kind   (shift_e'(shift_kind)),
        .amt    (shift_amt),
        .cin    (flags_q.c),
        .out    (sh_out),
        .cout   (sh_cout),
        .cvalid (sh_cvalid)
    );

    always_comb begin
        if (op == OP_ADDW) begin
            operand2 = {{PAD_W{1'b0}}, imm[WIDE_IMM_W-1:0]};
        end else if (use_imm) begin
            operand2 = imm;
        end else begin
            operand2 = sh_out;
        end
    end

    alu_core #(.W(W)) u_core (
        .op       (op),
        .a        (op_a),
        .b        (operand2),
        .cin      (flags_q.c),
        .res      (res),
        .c_arith  (c_arith),
        .v_arith  (v_arith),
        .is_logic (is_logic)
    );

    always_comb begin
        flags_d.n = res[W-1];
        flags_d.z = (res == '0);
        if (is_logic) begin
            flags_d.c = (!use_imm && sh_cvalid) ? sh_cout : flags_q.c;
            flags_d.v = flags_q.v;
        end else begin
            flags_d.c = c_arith;
            flags_d.v = v_arith;
        end
        flag_we = set_flags && (op != OP_ADDW);
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .nxt   (flags_d),
        .cur   (flags_q)
    );

    assign result = res;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  opcode,
    input logic [31:0] op_a,
    input logic        use_imm,
    input logic [2:0]  shift_kind,
    input logic        set_flags,
    input logic [31:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_c,
    input logic        flag_v
);
    logic is_log;
    assign is_log = (opcode == OP_AND) || (opcode == OP_EOR) || (opcode == OP_ORR) ||
                    (opcode == OP_ORN) || (opcode == OP_BIC);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    p_wide_noflags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ADDW) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && opcode != OP_ADDW) |=> (flag_z == ($past(result) == 32'd0)));

    p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && opcode != OP_ADDW) |=> (flag_n == $past(result[31])));

    p_logic_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && is_log) |=> $stable(flag_v));

    p_rrx_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_ORR && op_a == 32'd0 && !use_imm && shift_kind == SH_RRX)
        |-> (result[31] == flag_c));
endmodule

bind alu_exec_unit alu_exec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .op_a       (op_a),
    .use_imm    (use_imm),
    .shift_kind (shift_kind),
    .set_flags  (set_flags),
    .result     (result),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .flag_v     (flag_v)
);

// File: tb/sim_alu_exec_unit.sv
module sim_alu_exec_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] imm;
        logic        ui;
        logic [2:0]  sk;
        logic [4:0]  sa;
        logic        sf;
        logic [31:0] exp_res;
        logic [3:0]  exp_f;   // {N,Z,C,V}
    } vec_t;

    // every case begins from N=0 Z=0 C=1 V=0
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  32'h7F0E0C2D, 32'h1048B3C5, 32'h0,        1'b0, 3'd3, 5'd24, 1'b1, 32'hC7C1D13E, 4'b1001},
        '{4'd10, 32'h2468ACE0, 32'h0,        32'h00000F1B, 1'b1, 3'd0, 5'd0,  1'b0, 32'h2468BBFB, 4'b0010},
        '{4'd4,  32'h2468ACE0, 32'h1048B3C5, 32'h0,        1'b0, 3'd0, 5'd0,  1'b1, 32'h141FF91B, 4'b0010},
        '{4'd6,  32'h2468ACE0, 32'h0,        32'h00000012, 1'b1, 3'd0, 5'd0,  1'b1, 32'hDB975332, 4'b1000},
        '{4'd5,  32'h7F0E0C2D, 32'h1048B3C5, 32'h0,        1'b0, 3'd0, 5'd12, 1'b1, 32'hF3D1BC2D, 4'b1001},
        '{4'd1,  32'h2468ACE0, 32'h1048B3C5, 32'h0,        1'b0, 3'd1, 5'd4,  1'b1, 32'h256C27DC, 4'b0000},
        '{4'd9,  32'h2468ACE0, 32'h1048B3C5, 32'h0,        1'b0, 3'd4, 5'd0,  1'b1, 32'h2448A400, 4'b0010},
        '{4'd0,  32'h7F0E0C2D, 32'h2468ACE0, 32'h0,        1'b0, 3'd2, 5'd28, 1'b1, 32'h00000000, 4'b0100},
        '{4'd7,  32'h2468ACE0, 32'h1048B3C5, 32'h0,        1'b0, 3'd0, 5'd0,  1'b0, 32'h3468BFE5, 4'b0010},
        '{4'd8,  32'h2468ACE0, 32'h0,        32'hB600B600, 1'b1, 3'd0, 5'd0,  1'b0, 32'h6DFFEDFF, 4'b0010}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] imm = '0;
    logic        use_imm = 1'b0;
    logic [2:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    alu_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .imm(imm), .use_imm(use_imm), .shift_kind(shift_kind), .shift_amt(shift_amt),
        .set_flags(set_flags), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s result act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chkf(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {flag_n, flag_z, flag_c, flag_v};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s flags NZCV act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] im, input logic ui, input logic [2:0] sk,
                         input logic [4:0] sa, input logic sf);
        opcode = op; op_a = a; op_b = b; imm = im;
        use_imm = ui; shift_kind = sk; shift_amt = sa; set_flags = sf;
    endtask

    // flags -> N0 Z0 C1 V0 via SUBS 1 - 0
    task automatic prep_flags();
        @(negedge clk);
        drive(4'd4, 32'd1, 32'd0, 32'd0, 1'b1, 3'd0, 5'd0, 1'b1);
        @(negedge clk);
    endtask

    // flags -> N0 Z1 C0 V0 via ADDS 0 + 0
    task automatic clear_carry();
        @(negedge clk);
        drive(4'd2, 32'd0, 32'd0, 32'd0, 1'b1, 3'd0, 5'd0, 1'b1);
        @(negedge clk);
    endtask

    // apply at a negedge, check result mid-cycle and flags one edge later
    task automatic apply(input string tag, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] im, input logic ui,
                         input logic [2:0] sk, input logic [4:0] sa, input logic sf,
                         input logic [31:0] er, input logic [3:0] ef);
        drive(op, a, b, im, ui, sk, sa, sf);
        #2;
        chk32(tag, result, er);
        @(negedge clk);
        chkf(tag, ef);
        set_flags = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chkf("R6 flags in reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chkf("R6 flags after reset, no update", 4'b0000);

        // table cases: R1 R2 R3 R4 R5 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            prep_flags();
            apply($sformatf("R1/R2/R3 table case %0d", i), VECS[i].op, VECS[i].a, VECS[i].b,
                  VECS[i].imm, VECS[i].ui, VECS[i].sk, VECS[i].sa, VECS[i].sf,
                  VECS[i].exp_res, VECS[i].exp_f);
        end

        // R8 R7: unsigned carry out with zero result
        prep_flags();
        apply("R8 ADDS carry to zero", 4'd2, 32'hFFFFFFFF, 0, 32'd1, 1'b1, 3'd0, 5'd0, 1'b1,
              32'h0, 4'b0110);
        // R9: signed overflow on add
        prep_flags();
        apply("R9 ADDS overflow", 4'd2, 32'h7FFFFFFF, 0, 32'd1, 1'b1, 3'd0, 5'd0, 1'b1,
              32'h80000000, 4'b1001);
        // R8: equal subtract, no borrow
        prep_flags();
        apply("R8 SUBS equal", 4'd4, 32'd5, 32'd5, 0, 1'b0, 3'd0, 5'd0, 1'b1,
              32'h0, 4'b0110);
        // R1: add-with-carry when C=0
        clear_carry();
        apply("R1 ADCS with C=0", 4'd3, 32'd3, 32'd4, 0, 1'b0, 3'd0, 5'd0, 1'b1,
              32'd7, 4'b0000);
        // R11: ASR sign fill and last-bit carry
        prep_flags();
        apply("R11 ASR 4", 4'd0, 32'hFFFFFFFF, 32'h80000010, 0, 1'b0, 3'd2, 5'd4, 1'b1,
              32'hF8000001, 4'b1000);
        prep_flags();
        apply("R11 ASR 5", 4'd0, 32'hFFFFFFFF, 32'h80000010, 0, 1'b0, 3'd2, 5'd5, 1'b1,
              32'hFC000000, 4'b1010);
        // R10: immediate and zero amount keep C
        prep_flags();
        apply("R10 ORRS immediate keeps C", 4'd7, 32'd0, 0, 32'd0, 1'b1, 3'd0, 5'd0, 1'b1,
              32'h0, 4'b0110);
        prep_flags();
        apply("R10 ORRS LSL 0 keeps C", 4'd7, 32'd0, 32'h80000000, 0, 1'b0, 3'd0, 5'd0, 1'b1,
              32'h80000000, 4'b1010);
        // R3: ROR carry from result msb
        clear_carry();
        apply("R3 ROR 1 carry", 4'd7, 32'd0, 32'd1, 0, 1'b0, 3'd3, 5'd1, 1'b1,
              32'h80000000, 4'b1010);
        // R4: RRX inserts C=0 and carries out bit 0
        clear_carry();
        apply("R4 RRX with C=0", 4'd7, 32'd0, 32'd1, 0, 1'b0, 3'd4, 5'd9, 1'b1,
              32'h0, 4'b0110);
        // R5: wide add ignores upper imm bits and set_flags
        prep_flags();
        apply("R5 wide add with set_flags", 4'd10, 32'd1, 0, 32'hFFFFF123, 1'b0, 3'd0, 5'd0,
              1'b1, 32'h00000124, 4'b0010);
        // R6: no update without set_flags
        prep_flags();
        apply("R6 SUB without set_flags", 4'd4, 32'd5, 32'd5, 0, 1'b0, 3'd0, 5'd0, 1'b0,
              32'h0, 4'b0010);
        // R7: negative result sets N
        prep_flags();
        apply("R7 EORS negative", 4'd1, 32'h80000000, 32'd0, 0, 1'b0, 3'd0, 5'd0, 1'b1,
              32'h80000000, 4'b1010);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule